// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences the conversions of a successive-approximation ADC. An 8-bit control word sets the power state, the reference choice, the ADC clock rate, the track time and the enabled hardware triggers. The ADC clock is a one-cycle tick derived from the master clock by a divider chosen from four codes. Each accepted start request opens a track window of a programmable number of ADC clocks. A fixed conversion window of seventeen ADC clocks follows. A single-cycle completion strobe closes the sequence.

A conversion can be started in three ways. Software can pulse a start input. A timer overflow pulse starts one when its enable bit is set. A falling edge on an asynchronous, active-low convert-start pin starts one when its enable bit is set; the pin is first synchronised. The divider and track settings are captured when a conversion starts. Start requests that arrive while a sequence is running are dropped. The reference-select bit has no effect on timing and only appears on an output.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control word is 0x00: all outputs are low, and no start source can begin a conversion.
- R2: Control bit 6 appears on `ref_ext` from the cycle after the write, with no effect on timing.
- R3: Control bits 5:4 set the ADC clock period N in master clocks: 00 gives 8, 01 gives 4, 10 gives 16 and 11 gives 32. During a sequence `adc_tick` pulses once every N cycles. Its first pulse is in cycle N-1 of the track window, counting that window's first cycle as 0.
- R4: Control bits 3:2 set the track length A in ADC clocks: 00, 01, 10 and 11 give 1, 2, 3 and 4. `sample_hold` is high for exactly A*N cycles, starting in the cycle after the edge that accepts the start.
- R5: After the track window, `conv_busy` stays high with `sample_hold` low for exactly 17*N cycles. `conv_busy` is also high during the track window.
- R6: `conv_done` is high for exactly one cycle, immediately after `conv_busy` falls, and the block is then idle.
- R7: A one-cycle `sw_start` pulse begins a conversion when control bit 7 is 1, whatever bits 1:0 hold. When bit 7 is 0 it does nothing.
- R8: A one-cycle `timer_ovf` pulse begins a conversion only when bits 7 and 1 are both 1.
- R9: A falling edge on `convst_n` begins a conversion only when bits 7 and 0 are both 1. Two synchroniser stages put `sample_hold` high in the sample after the third rising edge that sees the pin low. A rising edge starts nothing.
- R10: A start request from any source during the track, conversion or done cycles is ignored and is not queued. The running sequence keeps its length, and nothing follows it.
- R11: A divider or track code written during a sequence does not change that sequence. It applies from the next start.
- R12: Clearing bit 7 during a sequence returns the block to idle one cycle after the written value takes hold, and no `conv_done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word value |
| sw_start | input | 1 | Software single-shot start pulse |
| timer_ovf | input | 1 | Timer overflow start pulse |
| convst_n | input | 1 | Asynchronous active-low convert-start pin |
| ref_ext | output | 1 | Reference select (1 external, 0 internal) |
| adc_tick | output | 1 | ADC clock tick, one master cycle wide |
| sample_hold | output | 1 | Track window active |
| conv_busy | output | 1 | Track or conversion in progress |
| conv_done | output | 1 | One-cycle completion strobe |

## Verification
The bench drives and samples one time unit after each rising edge. A pulse on `sw_start` or `timer_ovf` is therefore seen as `sample_hold` high at the very next sample. A falling edge on `convst_n` is seen only at the third sample, and the bench checks the two samples before it as low. From the first track sample, the bench counts consecutive samples in each phase and compares the counts with A*N, 17*N and one done cycle, all derived from the control codes. A power-down write is checked one sample after it takes hold, and ignored starts are checked by the total busy length and by a quiet period after `conv_done`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DIV_W     = 6;
    localparam int CONV_CLKS = 17;
    localparam int LEFT_W    = $clog2(CONV_CLKS + 1);
    localparam int SYNC_LEN  = 2;

    typedef struct packed {
        logic       pwr;
        logic       ref_ext;
        logic [1:0] div_code;
        logic [1:0] acq_code;
        logic       tmr_en;
        logic       ext_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_CONV,
        ST_DONE
    } seq_state_e;

    // Non-monotonic divider code to master clocks per ADC clock
    function automatic logic [DIV_W-1:0] div_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return DIV_W'(8);
            2'b01:   return DIV_W'(4);
            2'b10:   return DIV_W'(16);
            default: return DIV_W'(32);
        endcase
    endfunction

    // Track-time code to ADC clocks
    function automatic logic [LEFT_W-1:0] acq_ticks(input logic [1:0] code);
        return LEFT_W'(code) + LEFT_W'(1);
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
    import adc_seq_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] ratio,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == ratio - W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // R3
    div_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(tick)) |-> (cnt_q == $past(cnt_q) + W'(1)));

    // R3
    div_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < ratio));

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int SYNC = SYNC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_start,
    input  logic timer_ovf,
    input  logic convst_n,
    input  logic tmr_en,
    input  logic ext_en,
    output logic trig
);

    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            ext_fall;

    generate
        if (SYNC == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= convst_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC-2:0], convst_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[SYNC-1];
    end

    assign ext_fall = prev_q && !sync_q[SYNC-1];
    assign trig     = sw_start || (tmr_en && timer_ovf) || (ext_en && ext_fall);

    // R9
    ext_fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        ext_fall |=> !ext_fall);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int W     = DIV_W,
    parameter int LW    = LEFT_W,
    parameter int NCONV = CONV_CLKS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          powered,
    input  logic          trig,
    input  logic          tick,
    input  logic [1:0]    div_code,
    input  logic [1:0]    acq_code,
    output seq_state_e    state_q,
    output logic [W-1:0]  ratio_q
);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ratio_q <= div_ratio(2'b00);
            left_q  <= '0;
        end else if (!powered) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (trig) begin
                        state_q <= ST_ACQ;
                        ratio_q <= div_ratio(div_code);
                        left_q  <= acq_ticks(acq_code);
                    end
                end
                ST_ACQ: begin
                    if (tick) begin
                        if (left_q == LW'(1)) begin
                            state_q <= ST_CONV;
                            left_q  <= LW'(NCONV);
                        end else begin
                            left_q <= left_q - LW'(1);
                        end
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        if (left_q == LW'(1)) state_q <= ST_DONE;
                        else                  left_q  <= left_q - LW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R5
    done_after_conv_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |-> ($past(state_q) == ST_CONV));

    // R12
    pwr_down_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !powered |=> (state_q == ST_IDLE));

    // R11
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(ratio_q));

    // R10
    acq_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACQ && $past(state_q) != ST_IDLE) |-> ($past(state_q) == ST_ACQ));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       sw_start,
    input  logic       timer_ovf,
    input  logic       convst_n,
    output logic       ref_ext,
    output logic       adc_tick,
    output logic       sample_hold,
    output logic       conv_busy,
    output logic       conv_done
);

    ctrl_t            ctrl_q;
    seq_state_e       state;
    logic [DIV_W-1:0] ratio;
    logic             trig;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    adc_trig_sel #(.SYNC(SYNC_LEN)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .sw_start  (sw_start),
        .timer_ovf (timer_ovf),
        .convst_n  (convst_n),
        .tmr_en    (ctrl_q.tmr_en),
        .ext_en    (ctrl_q.ext_en),
        .trig      (trig)
    );

    adc_seq_fsm #(.W(DIV_W), .LW(LEFT_W), .NCONV(CONV_CLKS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .powered  (ctrl_q.pwr),
        .trig     (trig),
        .tick     (adc_tick),
        .div_code (ctrl_q.div_code),
        .acq_code (ctrl_q.acq_code),
        .state_q  (state),
        .ratio_q  (ratio)
    );

    adc_clk_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .run   (conv_busy),
        .ratio (ratio),
        .tick  (adc_tick)
    );

    assign ref_ext     = ctrl_q.ref_ext;
    assign sample_hold = (state == ST_ACQ);
    assign conv_busy   = (state == ST_ACQ) || (state == ST_CONV);
    assign conv_done   = (state == ST_DONE);

    // R1
    unpowered_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.pwr && !$past(ctrl_q.pwr)) |-> (!conv_busy && !conv_done));

endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       sw_start = 1'b0;
    logic       timer_ovf = 1'b0;
    logic       convst_n = 1'b1;
    logic       ref_ext, adc_tick, sample_hold, conv_busy, conv_done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    adc_seq_top dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .sw_start(sw_start), .timer_ovf(timer_ovf), .convst_n(convst_n),
        .ref_ext(ref_ext), .adc_tick(adc_tick), .sample_hold(sample_hold),
        .conv_busy(conv_busy), .conv_done(conv_done)
    );

    always #4 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        step();
        ctrl_we = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            0: return 8;
            1: return 4;
            2: return 16;
            default: return 32;
        endcase
    endfunction

    // Starts on the first track sample; ends on the sample after the done cycle
    task automatic measure(output int acq, output int conv, output int ticks,
                           output int first_tick, output int done_ok, output int idle_ok);
        acq = 0; conv = 0; ticks = 0; first_tick = -1;
        while (sample_hold && acq < 5000) begin
            if (adc_tick) begin
                if (first_tick < 0) first_tick = acq;
                ticks++;
            end
            acq++;
            step();
        end
        while (conv_busy && !sample_hold && conv < 5000) begin
            if (adc_tick) ticks++;
            conv++;
            step();
        end
        done_ok = (conv_done && !conv_busy) ? 1 : 0;
        step();
        idle_ok = (!conv_done && !conv_busy && !sample_hold) ? 1 : 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int a, c, tk, ft, dn, idl, n, aq_len, b;
        repeat (5) step();
        rst = 1'b0;
        step();

        // R1 reset state and no start while unpowered
        chk("R1 ref_ext", ref_ext, 0);
        chk("R1 busy", conv_busy, 0);
        chk("R1 sample_hold", sample_hold, 0);
        chk("R1 done", conv_done, 0);
        sw_start = 1'b1; timer_ovf = 1'b1; convst_n = 1'b0;
        repeat (4) step();
        sw_start = 1'b0; timer_ovf = 1'b0; convst_n = 1'b1;
        chk("R1 no start after reset", conv_busy, 0);
        repeat (4) step();

        // R2 reference select output
        wr(8'h40);
        chk("R2 ref_ext set", ref_ext, 1);
        chk("R2 no start", conv_busy, 0);
        wr(8'h00);
        chk("R2 ref_ext clear", ref_ext, 0);

        // R3 R4 R5 R6 R7 sweep of all divider and track codes
        for (int ck = 0; ck < 4; ck++) begin
            for (int aq = 0; aq < 4; aq++) begin
                n = ratio_of(ck);
                aq_len = aq + 1;
                wr({1'b1, 1'b0, 2'(ck), 2'(aq), 2'b00});
                pulse_sw();
                chk("R7 sw start", sample_hold, 1);
                measure(a, c, tk, ft, dn, idl);
                chk("R4 track length", a, aq_len * n);
                chk("R5 conversion length", c, 17 * n);
                chk("R3 tick count", tk, aq_len + 17);
                chk("R3 first tick", ft, n - 1);
                chk("R6 done strobe", dn, 1);
                chk("R6 idle after done", idl, 1);
            end
        end

        // R7 software start ignored when powered down
        wr(8'h10);
        pulse_sw();
        chk("R7 unpowered sw", conv_busy, 0);
        step();
        chk("R7 unpowered sw later", conv_busy, 0);

        // R8 timer trigger gating
        wr(8'h90);
        timer_ovf = 1'b1; step(); timer_ovf = 1'b0;
        chk("R8 timer disabled", conv_busy, 0);
        step();
        chk("R8 timer disabled later", conv_busy, 0);
        wr(8'h92);
        timer_ovf = 1'b1; step(); timer_ovf = 1'b0;
        chk("R8 timer start", sample_hold, 1);
        measure(a, c, tk, ft, dn, idl);
        chk("R8 track length", a, 4);
        chk("R8 conversion length", c, 68);
        chk("R8 done", dn, 1);

        // R9 external pin gating and latency
        wr(8'h90);
        convst_n = 1'b0;
        b = 0;
        repeat (5) begin step(); b += conv_busy; end
        convst_n = 1'b1;
        chk("R9 pin disabled", b, 0);
        repeat (4) step();
        wr(8'h91);
        convst_n = 1'b0;
        step();
        chk("R9 latency sample 1", sample_hold, 0);
        step();
        chk("R9 latency sample 2", sample_hold, 0);
        step();
        chk("R9 latency sample 3", sample_hold, 1);
        measure(a, c, tk, ft, dn, idl);
        chk("R9 track length", a, 4);
        chk("R9 conversion length", c, 68);
        convst_n = 1'b1;
        b = 0;
        repeat (6) begin step(); b += conv_busy; end
        chk("R9 rising edge ignored", b, 0);

        // R10 starts during a sequence are dropped
        wr(8'h93);
        pulse_sw();
        b = 0;
        repeat (5) begin b += conv_busy; step(); end
        sw_start = 1'b1; timer_ovf = 1'b1; convst_n = 1'b0;
        b += conv_busy; step();
        sw_start = 1'b0; timer_ovf = 1'b0; convst_n = 1'b1;
        while (conv_busy && b < 5000) begin b++; step(); end
        chk("R10 busy length", b, 72);
        sw_start = 1'b1; timer_ovf = 1'b1;
        chk("R10 done while requested", conv_done, 1);
        step();
        sw_start = 1'b0; timer_ovf = 1'b0;
        b = 0;
        repeat (10) begin b += conv_busy; step(); end
        chk("R10 no queued start", b, 0);

        // R11 code change mid-sequence applies from next start
        wr(8'h90);
        pulse_sw();
        b = 0;
        repeat (3) begin b += conv_busy; step(); end
        ctrl_we = 1'b1; ctrl_wdata = 8'hBC;
        b += conv_busy; step();
        ctrl_we = 1'b0;
        while (conv_busy && b < 5000) begin b++; step(); end
        chk("R11 old timing kept", b, 72);
        chk("R11 done", conv_done, 1);
        step();
        pulse_sw();
        measure(a, c, tk, ft, dn, idl);
        chk("R11 new track length", a, 128);
        chk("R11 new conversion length", c, 544);

        // R12 power-down aborts
        wr(8'h90);
        pulse_sw();
        repeat (10) step();
        wr(8'h10);
        chk("R12 still busy at write", conv_busy, 1);
        step();
        chk("R12 idle after power-down", conv_busy, 0);
        chk("R12 sample_hold low", sample_hold, 0);
        b = 0;
        repeat (100) begin b += conv_done; step(); end
        chk("R12 no done", b, 0);
        wr(8'h90);
        step();
        chk("R12 no spontaneous start", conv_busy, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule